// File: doc/BRIEF.md
# Receiver CDR Manual-Lock Reset Sequencer

This block brings up a receive-only serial channel whose clock-data-recovery loop is steered by hand instead of switching itself between lock-to-reference and lock-to-data. After a system reset it holds the analog and digital receiver resets and keeps the recovery loop tracking the reference clock. It then waits for the calibration engine to report idle and for the receiver PLL to report lock. Only after a settling delay does it move the loop onto the incoming data. A second delay later it releases the digital reset and raises a ready flag.

Both delays are set in microseconds and converted to clock cycles from an integer clock-frequency parameter in MHz. At the default 200 MHz that gives 3000 cycles for the lock settle and 800 cycles for the data settle. The calibration-busy and PLL-lock inputs are asynchronous, so each passes through a two-stage synchronizer. The busy synchronizer resets to "busy" and the lock synchronizer resets to "unlocked". If PLL lock is lost at any point after the analog reset is released, the sequencer falls back to waiting for lock and runs the full settle again. The system reset is active low, asserts asynchronously and is released through a two-stage synchronizer.

Top module: `rxcdr_rst_seq`

## Requirements
- R1: While `arst_ni` is low, the outputs take these values without waiting for a clock edge: `ana_rst_o`=1, `dig_rst_o`=1, `cdr_ref_lock_o`=1, `cdr_data_lock_o`=0, `seq_ready_o`=0.
- R2: The release of `arst_ni` passes through RST_STAGES (2) flops. After that, `ana_rst_o` stays high for at least ANA_MIN_CYC (2) cycles. With calibration idle from the start, `ana_rst_o` falls on rising edge 5 after `arst_ni` rises.
- R3: `ana_rst_o` falls only once the synchronized busy flag is low. If busy is first sampled low at rising edge k after reset release, `ana_rst_o` falls on edge max(k+2, 5), counting edges from the release of `arst_ni`.
- R4: While `ana_rst_o` is high, and while the block waits for PLL lock, `dig_rst_o`=1, `cdr_ref_lock_o`=1, `cdr_data_lock_o`=0 and `seq_ready_o`=0.
- R5: Exactly one of `cdr_ref_lock_o` and `cdr_data_lock_o` is high at every cycle, so the hand-over between them happens on a single clock edge.
- R6: Once the analog reset is released, `cdr_data_lock_o` rises on edge SYNC_STAGES+1+LOCK_WAIT_US·CLK_MHZ, which is 3003 at the defaults. The count starts at the first edge that samples `rxpll_lock_i` high, and `rxpll_lock_i` must stay high throughout.
- R7: `dig_rst_o` falls exactly DATA_WAIT_US·CLK_MHZ (800) cycles after `cdr_data_lock_o` rises.
- R8: `seq_ready_o` rises on the same edge on which `dig_rst_o` falls. While it is high, `ana_rst_o`=0, `dig_rst_o`=0 and `cdr_data_lock_o`=1.
- R9: If `rxpll_lock_i` goes low after the analog reset has been released, the block returns to the lock-wait state on edge SYNC_STAGES+1 (3) after the first edge that samples it low. There `dig_rst_o`=1, `cdr_ref_lock_o`=1, `cdr_data_lock_o`=0 and `seq_ready_o`=0. When lock returns, the full lock settle of R6 starts again.
- R10: Asserting `arst_ni` in the middle of a sequence restores the R1 values at once. The next release then runs the whole sequence again from the analog-reset phase.
- R11: Changes on `cal_busy_i` after `ana_rst_o` has fallen have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel receive clock, frequency CLK_MHZ |
| arst_ni | input | 1 | System reset, active low, asynchronous assert |
| cal_busy_i | input | 1 | Calibration busy flag, asynchronous |
| rxpll_lock_i | input | 1 | Receiver PLL lock indication, asynchronous |
| ana_rst_o | output | 1 | Analog receiver reset, active high |
| dig_rst_o | output | 1 | Digital receiver reset, active high |
| cdr_ref_lock_o | output | 1 | Forces the recovery loop onto the reference clock |
| cdr_data_lock_o | output | 1 | Forces the recovery loop onto the received data |
| seq_ready_o | output | 1 | Sequence complete, channel usable |

## Verification
The assertions assume that busy and PLL lock are level signals. They must hold each new value for at least the synchronizer depth, so that no pulse is lost between the two flops. They also assume that the system reset is the only event that moves the block back into the analog-reset phase. The stimulus follows these assumptions:
- Inputs and reset change only at falling clock edges.
- Busy is held high for a random number of cycles before it drops.
- Lock is dropped at random points inside the lock settle, inside the data settle and after ready, and is held low for several cycles before it returns.
- Busy is pulsed only after the analog reset is gone, which is the case R11 covers.

// File: rtl/rxcdr_rst_pkg.sv
`timescale 1ns/1ps
package rxcdr_rst_pkg;

  // Sequencer phases, in the order a clean bring-up walks through them.
  typedef enum logic [2:0] {
    ST_ANA_HOLD  = 3'd0,
    ST_WAIT_LOCK = 3'd1,
    ST_LOCK_DLY  = 3'd2,
    ST_DATA_DLY  = 3'd3,
    ST_READY     = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic ana_rst;
    logic dig_rst;
    logic ref_lock;
    logic data_lock;
    logic ready;
  } seq_out_t;

  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic seq_out_t decode_outputs(input seq_state_e st);
    seq_out_t o;
    o = '{ana_rst: 1'b1, dig_rst: 1'b1, ref_lock: 1'b1, data_lock: 1'b0, ready: 1'b0};
    unique case (st)
      ST_ANA_HOLD:  o.ana_rst = 1'b1;
      ST_WAIT_LOCK,
      ST_LOCK_DLY:  o.ana_rst = 1'b0;
      ST_DATA_DLY: begin
        o.ana_rst   = 1'b0;
        o.ref_lock  = 1'b0;
        o.data_lock = 1'b1;
      end
      ST_READY: begin
        o.ana_rst   = 1'b0;
        o.dig_rst   = 1'b0;
        o.ref_lock  = 1'b0;
        o.data_lock = 1'b1;
        o.ready     = 1'b1;
      end
      default: o.ana_rst = 1'b1;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rxcdr_rst_sync.sv
`timescale 1ns/1ps
// Reset bridge: asserts asynchronously, releases after STAGES clock edges.
module rxcdr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/rxcdr_bit_sync.sv
`timescale 1ns/1ps
// Multi-bit level synchronizer; each bit gets its own flop chain and reset value.
module rxcdr_bit_sync #(
  parameter int unsigned       WIDTH     = 1,
  parameter int unsigned       STAGES    = 2,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RESET_VAL[b]}};
      else         ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end

    assign q_o[b] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/rxcdr_tick_cnt.sv
`timescale 1ns/1ps
// Saturating up-counter with synchronous clear and explicit clock enable.
module rxcdr_tick_cnt #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                         cnt_d = '0;
    else if (en_i && (cnt_q != '1))    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rxcdr_rst_seq.sv
`timescale 1ns/1ps
module rxcdr_rst_seq
  import rxcdr_rst_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned LOCK_WAIT_US = 15,
  parameter int unsigned DATA_WAIT_US = 4,
  parameter int unsigned ANA_MIN_CYC  = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_STAGES   = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic cal_busy_i,
  input  logic rxpll_lock_i,
  output logic ana_rst_o,
  output logic dig_rst_o,
  output logic cdr_ref_lock_o,
  output logic cdr_data_lock_o,
  output logic seq_ready_o
);

  localparam int unsigned LOCK_CYC = us_to_cycles(LOCK_WAIT_US, CLK_MHZ);
  localparam int unsigned DATA_CYC = us_to_cycles(DATA_WAIT_US, CLK_MHZ);
  localparam int unsigned MAX_CYC  = max3(LOCK_CYC, DATA_CYC, ANA_MIN_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned RUN_W    = CNT_W + 1;

  localparam logic [CNT_W-1:0] ANA_LIM  = CNT_W'(ANA_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LIM = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_CYC - 1);

  // ---------------------------------------------------------------- reset
  logic rst_n;

  rxcdr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n)
  );

  // ----------------------------------------------------- input synchronizers
  // bit 0: busy (resets to busy), bit 1: PLL lock (resets to unlocked)
  logic [1:0] stat_s;
  logic       busy_s, lock_s;

  rxcdr_bit_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(2'b01)
  ) u_stat_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({rxpll_lock_i, cal_busy_i}),
    .q_o   (stat_s)
  );

  assign busy_s = stat_s[0];
  assign lock_s = stat_s[1];

  // ------------------------------------------------------------ state/timer
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_en;
  logic             ana_done, lock_done, data_done;

  assign ana_done  = (cnt_q >= ANA_LIM);
  assign lock_done = (cnt_q >= LOCK_LIM);
  assign data_done = (cnt_q >= DATA_LIM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ANA_HOLD:  if (ana_done && !busy_s) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (lock_s)              state_d = ST_LOCK_DLY;
      ST_LOCK_DLY: begin
        if (!lock_s)        state_d = ST_WAIT_LOCK;
        else if (lock_done) state_d = ST_DATA_DLY;
      end
      ST_DATA_DLY: begin
        if (!lock_s)        state_d = ST_WAIT_LOCK;
        else if (data_done) state_d = ST_READY;
      end
      ST_READY:     if (!lock_s)             state_d = ST_WAIT_LOCK;
      default:                               state_d = ST_ANA_HOLD;
    endcase
  end

  assign cnt_clr = (state_d != state_q);
  assign cnt_en  = (state_q == ST_ANA_HOLD) || (state_q == ST_LOCK_DLY) ||
                   (state_q == ST_DATA_DLY);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ANA_HOLD;
    else        state_q <= state_d;
  end

  rxcdr_tick_cnt #(.WIDTH(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt_q)
  );

  // ------------------------------------------------------------- outputs
  seq_out_t outs;

  assign outs            = decode_outputs(state_q);
  assign ana_rst_o       = outs.ana_rst;
  assign dig_rst_o       = outs.dig_rst;
  assign cdr_ref_lock_o  = outs.ref_lock;
  assign cdr_data_lock_o = outs.data_lock;
  assign seq_ready_o     = outs.ready;

  // ---------------------------------------------------------- assertions
  // Run-length monitors that bound the settle windows without deep $past.
  logic [RUN_W-1:0] lock_run_q, data_run_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      lock_run_q <= '0;
      data_run_q <= '0;
    end else begin
      if (!lock_s)                 lock_run_q <= '0;
      else if (lock_run_q != '1)   lock_run_q <= lock_run_q + 1'b1;
      if (!cdr_data_lock_o)        data_run_q <= '0;
      else if (data_run_q != '1)   data_run_q <= data_run_q + 1'b1;
    end
  end

  a_r3_ana_release_after_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(ana_rst_o) |-> !$past(busy_s));

  a_r5_single_cdr_mode: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones({cdr_ref_lock_o, cdr_data_lock_o}) == 1);

  a_r6_lock_settled: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(cdr_data_lock_o) |-> (lock_run_q >= RUN_W'(LOCK_CYC)));

  a_r7_data_settled: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(dig_rst_o) |-> (data_run_q >= RUN_W'(DATA_CYC)));

  a_r8_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_n)
    seq_ready_o |-> (!ana_rst_o && !dig_rst_o && cdr_data_lock_o));

  a_r9_lock_loss_fallback: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!lock_s && !ana_rst_o) |=>
      (dig_rst_o && cdr_ref_lock_o && !cdr_data_lock_o && !seq_ready_o));

endmodule

// File: tb/rxcdr_rst_seq_bench.sv
`timescale 1ns/1ps
module rxcdr_rst_seq_bench;

  localparam int CLK_MHZ  = 200;
  localparam int LOCK_CYC = 15 * CLK_MHZ;
  localparam int DATA_CYC = 4 * CLK_MHZ;
  localparam int SS       = 2;   // input synchronizer depth
  localparam int RS       = 2;   // reset release depth
  localparam int ANA      = 2;   // minimum analog reset cycles
  localparam int WD_CYC   = 150000;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic busy = 1'b1;
  logic lock = 1'b0;
  logic ana, dig, refl, datal, rdy;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rxcdr_rst_seq #(.CLK_MHZ(CLK_MHZ)) u_rxcdr_rst_seq (
    .clk_i          (clk),
    .arst_ni        (arst_n),
    .cal_busy_i     (busy),
    .rxpll_lock_i   (lock),
    .ana_rst_o      (ana),
    .dig_rst_o      (dig),
    .cdr_ref_lock_o (refl),
    .cdr_data_lock_o(datal),
    .seq_ready_o    (rdy)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Edge, counted from reset release, on which analog reset drops when busy
  // is first seen low at edge d+1.
  function automatic int exp_ana_edges(input int d);
    return imax(imax(d + 1 + SS, RS + 1 + SS), RS + ANA);
  endfunction

  function automatic int exp_data_edges();
    return SS + 1 + LOCK_CYC;
  endfunction

  function automatic int exp_drop_edges();
    return SS + 1;
  endfunction

  function automatic logic pick(input int sel);
    case (sel)
      0:       return ana;
      1:       return datal;
      2:       return dig;
      3:       return rdy;
      default: return refl;
    endcase
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic count_edges(input int sel, input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (pick(sel) !== lvl && n < limit);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=%0d cycles expected=completion", WD_CYC);
    finish_run();
  end

  initial begin
    int seed_dummy;
    int n;
    int n2;
    seed_dummy = $urandom(32'h5eed_0042);
    for (int it = 0; it < 8; it++) begin
      int mode;
      int d;
      int w;
      int x;
      mode = it % 4;
      // reset phase
      @(negedge clk);
      arst_n = 1'b0;
      busy   = 1'b1;
      lock   = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R1", "outputs in reset {ana,dig,ref,data,rdy}",
               int'({ana, dig, refl, datal, rdy}), 5'b11100);

      // release with random busy duration
      d = int'($urandom % 31);
      arst_n = 1'b1;
      fork
        begin
          if (d > 0) repeat (d) @(negedge clk);
          busy = 1'b0;
        end
        count_edges(0, 1'b0, 200, n);
      join
      check_eq((d + 1 + SS > RS + 1 + SS) ? "R3" : "R2", "edges to analog release", n,
               exp_ana_edges(d));
      check_eq("R4", "lock-wait outputs {dig,ref,data,rdy}",
               int'({dig, refl, datal, rdy}), 4'b1100);

      // busy pulse after analog release must be ignored
      w = 2 + int'($urandom % 15);
      busy = 1'b1;
      repeat (w) @(negedge clk);
      check_eq("R11", "outputs during late busy {ana,dig,ref,data,rdy}",
               int'({ana, dig, refl, datal, rdy}), 5'b01100);
      busy = 1'b0;

      // PLL lock, optionally lost inside the lock settle
      lock = 1'b1;
      if (mode == 1) begin
        x = 10 + int'($urandom % (LOCK_CYC - 20));
        repeat (x) @(negedge clk);
        check_eq("R6", "data lock before settle end", int'(datal), 0);
        lock = 1'b0;
        repeat (exp_drop_edges() + 1) @(negedge clk);
        check_eq("R9", "after loss in lock settle {dig,ref,data,rdy}",
                 int'({dig, refl, datal, rdy}), 4'b1100);
        lock = 1'b1;
      end
      count_edges(1, 1'b1, LOCK_CYC + 100, n);
      check_eq("R6", "edges from lock to data lock", n, exp_data_edges());
      check_eq("R5", "ref lock at hand-over", int'(refl), 0);

      if (mode == 3) begin
        x = 5 + int'($urandom % (DATA_CYC - 10));
        repeat (x) @(negedge clk);
        lock = 1'b0;
        count_edges(1, 1'b0, 50, n);
        check_eq("R9", "edges from loss to data lock drop", n, exp_drop_edges());
        check_eq("R9", "after loss in data settle {dig,ref,rdy}",
                 int'({dig, refl, rdy}), 3'b110);
        repeat (4) @(negedge clk);
        lock = 1'b1;
        count_edges(1, 1'b1, LOCK_CYC + 100, n);
        check_eq("R9", "full settle after relock", n, exp_data_edges());
      end

      count_edges(2, 1'b0, DATA_CYC + 100, n);
      check_eq("R7", "edges from data lock to digital release", n, DATA_CYC);
      check_eq("R8", "ready with digital release", int'(rdy), 1);
      check_eq("R8", "final outputs {ana,ref,data}", int'({ana, refl, datal}), 3'b001);

      if (mode == 2) begin
        repeat (5) @(negedge clk);
        check_eq("R8", "ready stays high", int'(rdy), 1);
        lock = 1'b0;
        count_edges(3, 1'b0, 50, n);
        check_eq("R9", "edges from loss to ready drop", n, exp_drop_edges());
        check_eq("R9", "after loss in ready {ana,dig,ref,data}",
                 int'({ana, dig, refl, datal}), 4'b0110);
        repeat (3) @(negedge clk);
        lock = 1'b1;
        count_edges(1, 1'b1, LOCK_CYC + 100, n);
        check_eq("R9", "relock settle from ready", n, exp_data_edges());
        count_edges(2, 1'b0, DATA_CYC + 100, n);
        check_eq("R7", "digital release after relock", n, DATA_CYC);
      end
    end

    // mid-run system reset, inputs already idle/locked
    repeat (7) @(negedge clk);
    arst_n = 1'b0;
    #1;
    check_eq("R10", "immediate reset outputs {ana,dig,ref,data,rdy}",
             int'({ana, dig, refl, datal, rdy}), 5'b11100);
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    count_edges(0, 1'b0, 200, n);
    check_eq("R10", "analog release after restart", n, exp_ana_edges(0));
    count_edges(1, 1'b1, LOCK_CYC + 100, n2);
    check_eq("R10", "data lock after restart", n + n2, exp_ana_edges(0) + 1 + LOCK_CYC);
    count_edges(2, 1'b0, DATA_CYC + 100, n);
    check_eq("R10", "digital release after restart", n, DATA_CYC);

    finish_run();
  end

endmodule